// File: doc/BRIEF.md
# Synchronous Burst Memory Cycle Controller

This block is the cycle-control logic of a pipelined synchronous burst memory with a configurable number of byte lanes. On every rising clock edge it samples three chip selects, two address-start strobes (one for the processor side, one for the cache-controller side), an advance strobe and the write controls (a global write, a byte-write qualifier and one enable per lane). From these it classifies the cycle as idle, deselect, begin read, begin write, continue or suspend. It drives a load pulse and a step pulse for an external burst address counter, one write strobe per byte lane, and a data-bus drive enable.

The processor-side start is qualified by the primary chip select and always opens a read. The controller-side start opens a read or a write depending on the decoded write controls. Once a burst is open, continue and suspend cycles keep its direction and do not look at the chip selects again. The output enable and the sleep input act without the clock on the drive enable. While asleep nothing is sampled and all state is kept. After wake-up, the first edges are ignored for a fixed number of cycles.

Top module: `burst_cycle_ctrl`

## Requirements
- R1: After reset, `addr_load`, `addr_step`, every `lane_we` bit and `dq_drive` are low, and no burst is open.
- R2: A start cycle deselects and closes the burst when any chip select is inactive (`sel_n` high, `sel_hi` low or `sel_lo_n` high). It produces no load, no strobe and no drive. `astart_cpu_n` is ignored while `sel_n` is high. After a deselect, cycles without a start produce nothing.
- R3: With all selects active, `astart_cpu_n` low begins a read: `addr_load` pulses and no lane strobe is issued, whatever the write inputs and `astart_ctl_n` are.
- R4: With all selects active, `astart_cpu_n` high and `astart_ctl_n` low, a burst begins with an `addr_load` pulse. It is a write if the write decode selects any lane and a read otherwise.
- R5: With both start strobes high and a burst open, `adv_n` low gives an `addr_step` pulse and `adv_n` high gives none (suspend). The burst keeps its direction, and the chip selects are not checked.
- R6: Write decode: `wr_all_n` low selects all lanes. With `wr_all_n` high and `wr_byte_n` low, lane i is selected where bit i of `lane_wr_n` is low (lane 0 is bit 0). Otherwise no lane is selected.
- R7: In a write burst, every begin, continue and suspend cycle strobes exactly the lanes of that cycle's decode. A read burst never strobes a lane.
- R8: `addr_load`, `addr_step` and `lane_we` are registered. Each is valid for the one clock cycle after the edge that sampled its cause and drops the cycle after.
- R9: `dq_drive` is high only after a read-type cycle of an open burst, and only while `oe_n` and `sleep` are low. Both `oe_n` and `sleep` act on it without a clock edge.
- R10: While `sleep` is high at an edge, every input is ignored, no load, step or strobe is produced, and the burst state is kept.
- R11: After `sleep` returns low, the next WAKE_CYCLES edges (default 2) are ignored the same way. The edge after them is sampled normally with the burst state from before sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Primary chip select, active low; also qualifies `astart_cpu_n` |
| sel_hi | input | 1 | Second chip select, active high |
| sel_lo_n | input | 1 | Third chip select, active low |
| astart_cpu_n | input | 1 | Processor-side address start, active low |
| astart_ctl_n | input | 1 | Controller-side address start, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_byte_n | input | 1 | Byte-write qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low, bit i = lane i |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request, active high |
| addr_load | output | 1 | Load external address into the burst counter |
| addr_step | output | 1 | Advance the burst counter |
| lane_we | output | LANES | Per-lane write strobes, active high |
| dq_drive | output | 1 | Enable for the data-bus output drivers |

## Verification
Two functions can act in the same cycle. A start on one strobe can arrive while the other strobe is also asserted or while a chip select is inactive. The asynchronous `oe_n` and `sleep` controls can also change while a read burst is in its data phase. The vector table provokes the first case with both start strobes low and write controls asserted, and with the processor start under an inactive primary select. The expected outcome is a read or a suspend, not a write. Directed steps change `oe_n` and `sleep` between edges of an open read and judge `dq_drive` at once. They then show the burst resuming with its old direction after wake-up.

// File: rtl/burst_ctl_pkg.sv
package burst_ctl_pkg;

   typedef enum logic [2:0] {
      OP_IDLE     = 3'd0,
      OP_DESEL    = 3'd1,
      OP_BEGIN_RD = 3'd2,
      OP_BEGIN_WR = 3'd3,
      OP_CONT     = 3'd4,
      OP_SUSP     = 3'd5,
      OP_HOLD     = 3'd6
   } cyc_op_t;

   function automatic logic op_is_begin(input cyc_op_t op);
      return (op == OP_BEGIN_RD) || (op == OP_BEGIN_WR);
   endfunction

   function automatic logic op_is_burst(input cyc_op_t op);
      return (op == OP_CONT) || (op == OP_SUSP);
   endfunction

endpackage

// File: rtl/bcc_write_decode.sv
module bcc_write_decode #(
   parameter int LANES = 4
) (
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_wr_n,
   output logic [LANES-1:0] lane_sel,
   output logic             any_write
);

   // one select per lane: global write wins, else byte qualifier plus lane enable
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_sel[g] = !wr_all_n || (!wr_byte_n && !lane_wr_n[g]);
   end

   assign any_write = |lane_sel;

endmodule

// File: rtl/bcc_wake_timer.sv
module bcc_wake_timer #(
   parameter int WAKE_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep,
   output logic awake
);

   if (WAKE_CYCLES == 0) begin : g_nowait
      assign awake = !sleep;
   end else begin : g_count
      localparam int CW = $clog2(WAKE_CYCLES + 1);
      localparam logic [CW-1:0] CNT_LOAD = CW'(WAKE_CYCLES);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (sleep) begin
            cnt_q <= CNT_LOAD;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign awake = !sleep && (cnt_q == '0);
   end

endmodule

// File: rtl/bcc_cycle_decide.sv
module bcc_cycle_decide
   import burst_ctl_pkg::*;
(
   input  logic    awake,
   input  logic    burst_open,
   input  logic    sel_n,
   input  logic    sel_hi,
   input  logic    sel_lo_n,
   input  logic    astart_cpu_n,
   input  logic    astart_ctl_n,
   input  logic    adv_n,
   input  logic    any_write,
   output cyc_op_t op
);

   logic cpu_start;
   logic new_addr;
   logic chip_on;

   // processor start is blocked by an inactive primary select
   assign cpu_start = !astart_cpu_n && !sel_n;
   assign new_addr  = cpu_start || !astart_ctl_n;
   assign chip_on   = !sel_n && sel_hi && !sel_lo_n;

   always_comb begin
      if (!awake) begin
         op = OP_HOLD;
      end else if (new_addr) begin
         if (!chip_on)       op = OP_DESEL;
         else if (cpu_start) op = OP_BEGIN_RD;
         else if (any_write) op = OP_BEGIN_WR;
         else                op = OP_BEGIN_RD;
      end else if (!burst_open) begin
         op = OP_IDLE;
      end else if (!adv_n) begin
         op = OP_CONT;
      end else begin
         op = OP_SUSP;
      end
   end

endmodule

// File: rtl/burst_cycle_ctrl.sv
module burst_cycle_ctrl
   import burst_ctl_pkg::*;
#(
   parameter int LANES       = 4,
   parameter int WAKE_CYCLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_n,
   input  logic             sel_hi,
   input  logic             sel_lo_n,
   input  logic             astart_cpu_n,
   input  logic             astart_ctl_n,
   input  logic             adv_n,
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_wr_n,
   input  logic             oe_n,
   input  logic             sleep,
   output logic             addr_load,
   output logic             addr_step,
   output logic [LANES-1:0] lane_we,
   output logic             dq_drive
);

   if (LANES < 1) begin : g_bad_lanes
      $error("burst_cycle_ctrl: LANES must be at least 1");
   end
   if (WAKE_CYCLES < 0 || WAKE_CYCLES > 255) begin : g_bad_wake
      $error("burst_cycle_ctrl: WAKE_CYCLES out of range");
   end

   logic             awake;
   logic [LANES-1:0] lane_sel;
   logic             any_write;
   cyc_op_t          op;

   logic             open_q;
   logic             dir_wr_q;
   logic             load_q;
   logic             step_q;
   logic [LANES-1:0] we_q;
   logic             rd_phase_q;

   bcc_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .sleep (sleep),
      .awake (awake)
   );

   bcc_write_decode #(.LANES(LANES)) u_wdec (
      .wr_all_n  (wr_all_n),
      .wr_byte_n (wr_byte_n),
      .lane_wr_n (lane_wr_n),
      .lane_sel  (lane_sel),
      .any_write (any_write)
   );

   bcc_cycle_decide u_dec (
      .awake        (awake),
      .burst_open   (open_q),
      .sel_n        (sel_n),
      .sel_hi       (sel_hi),
      .sel_lo_n     (sel_lo_n),
      .astart_cpu_n (astart_cpu_n),
      .astart_ctl_n (astart_ctl_n),
      .adv_n        (adv_n),
      .any_write    (any_write),
      .op           (op)
   );

   // burst bookkeeping: open flag and registered direction
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q   <= 1'b0;
         dir_wr_q <= 1'b0;
      end else begin
         case (op)
            OP_DESEL:    open_q <= 1'b0;
            OP_BEGIN_RD: begin open_q <= 1'b1; dir_wr_q <= 1'b0; end
            OP_BEGIN_WR: begin open_q <= 1'b1; dir_wr_q <= 1'b1; end
            default:     ;
         endcase
      end
   end

   // registered cycle outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q     <= 1'b0;
         step_q     <= 1'b0;
         we_q       <= '0;
         rd_phase_q <= 1'b0;
      end else begin
         load_q <= op_is_begin(op);
         step_q <= (op == OP_CONT);
         if (op == OP_BEGIN_WR || (op_is_burst(op) && dir_wr_q)) begin
            we_q <= lane_sel;
         end else begin
            we_q <= '0;
         end
         if (op == OP_BEGIN_RD) begin
            rd_phase_q <= 1'b1;
         end else if (op_is_burst(op)) begin
            rd_phase_q <= !dir_wr_q;
         end else if (op != OP_HOLD) begin
            rd_phase_q <= 1'b0;
         end
      end
   end

   assign addr_load = load_q;
   assign addr_step = step_q;
   assign lane_we   = we_q;
   assign dq_drive  = rd_phase_q && !oe_n && !sleep;

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             awake,
   input logic             sel_n,
   input logic             sel_hi,
   input logic             sel_lo_n,
   input logic             astart_cpu_n,
   input logic             astart_ctl_n,
   input logic             adv_n,
   input logic             wr_all_n,
   input logic             sleep,
   input logic             addr_load,
   input logic             addr_step,
   input logic [LANES-1:0] lane_we,
   input logic             dq_drive
);

   logic [1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             age_q <= 2'd0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   // R2
   sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_load && age_q != 2'd0) |-> $past(!sel_n && sel_hi && !sel_lo_n));

   // R3
   cpu_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q != 2'd0 && $past(awake && !astart_cpu_n && !sel_n && sel_hi && !sel_lo_n))
      |-> (addr_load && lane_we == '0));

   // R5
   step_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_step && age_q != 2'd0) |-> $past(!adv_n && astart_ctl_n));

   // R6
   all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q != 2'd0 && $past(awake && astart_cpu_n && !astart_ctl_n && !sel_n &&
                              sel_hi && !sel_lo_n && !wr_all_n))
      |-> (lane_we == '1));

   // R9
   no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_drive |-> (lane_we == '0));

   // R9
   sleep_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dq_drive);

   // R10 R11
   wake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && ($past(sleep) || $past(sleep, 2) || $past(sleep, 3)))
      |-> (!addr_load && !addr_step && lane_we == '0));

endmodule

bind burst_cycle_ctrl bcc_checker #(.LANES(LANES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .awake        (awake),
   .sel_n        (sel_n),
   .sel_hi       (sel_hi),
   .sel_lo_n     (sel_lo_n),
   .astart_cpu_n (astart_cpu_n),
   .astart_ctl_n (astart_ctl_n),
   .adv_n        (adv_n),
   .wr_all_n     (wr_all_n),
   .sleep        (sleep),
   .addr_load    (addr_load),
   .addr_step    (addr_step),
   .lane_we      (lane_we),
   .dq_drive     (dq_drive)
);

// File: tb/burst_cycle_ctrl_test.sv
`timescale 1ns/1ps
module burst_cycle_ctrl_test;

   localparam int LANES = 4;
   localparam int NVEC  = 17;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1, sel_hi = 1'b0, sel_lo_n = 1'b1;
   logic astart_cpu_n = 1'b1, astart_ctl_n = 1'b1, adv_n = 1'b1;
   logic wr_all_n = 1'b1, wr_byte_n = 1'b1;
   logic [LANES-1:0] lane_wr_n = '1;
   logic oe_n = 1'b0, sleep = 1'b0;
   logic addr_load, addr_step, dq_drive;
   logic [LANES-1:0] lane_we;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   burst_cycle_ctrl #(.LANES(LANES), .WAKE_CYCLES(2)) uut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
      .astart_cpu_n(astart_cpu_n), .astart_ctl_n(astart_ctl_n), .adv_n(adv_n),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n),
      .oe_n(oe_n), .sleep(sleep), .addr_load(addr_load), .addr_step(addr_step),
      .lane_we(lane_we), .dq_drive(dq_drive)
   );

   // fields: req | sel_n sel_hi sel_lo_n | cpu ctl adv | all byte | lanes_n | load step | we | dq
   localparam logic [22:0] VEC [NVEC] = '{
      {4'd8, 19'b101_111_11_1111_00_0000_0},  // R8 idle, nothing issued
      {4'd3, 19'b010_011_00_0000_10_0000_1},  // R3 cpu start reads despite writes
      {4'd5, 19'b101_110_11_1111_01_0000_1},  // R5 continue, selects off
      {4'd8, 19'b101_111_11_1111_00_0000_1},  // R8 suspend, step drops
      {4'd6, 19'b010_101_01_1111_10_1111_0},  // R6 global write
      {4'd7, 19'b101_110_10_1010_01_0101_0},  // R7 continue write, lanes 0 and 2
      {4'd7, 19'b101_111_11_1111_00_0000_0},  // R7 suspend write, no lanes
      {4'd4, 19'b010_101_10_1111_10_0000_1},  // R4 ctl start, no lane -> read
      {4'd2, 19'b110_011_11_1111_00_0000_1},  // R2 cpu start blocked -> suspend
      {4'd2, 19'b000_101_11_1111_00_0000_0},  // R2 second select low -> deselect
      {4'd2, 19'b101_110_11_1111_00_0000_0},  // R2 no burst after deselect
      {4'd6, 19'b010_101_10_0111_10_1000_0},  // R6 byte write lane 3
      {4'd2, 19'b011_101_01_1111_00_0000_0},  // R2 third select high -> deselect
      {4'd2, 19'b101_110_01_1111_00_0000_0},  // R2 write inputs ignored when closed
      {4'd6, 19'b010_101_00_1110_10_1111_0},  // R6 global overrides byte
      {4'd3, 19'b010_001_00_0000_10_0000_1},  // R3 both starts -> read
      {4'd5, 19'b101_110_00_0000_01_0000_1}   // R5 read burst keeps direction
   };

   task automatic check(input bit ok, input string req, input logic [7:0] got,
                        input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic apply(input logic [18:0] v);
      {sel_n, sel_hi, sel_lo_n} = v[18:16];
      {astart_cpu_n, astart_ctl_n, adv_n} = v[15:13];
      {wr_all_n, wr_byte_n} = v[12:11];
      lane_wr_n = v[10:7];
   endtask

   function automatic logic [6:0] outs();
      return {addr_load, addr_step, lane_we, dq_drive};
   endfunction

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(outs() == 7'b0, "R1", {1'b0, outs()}, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][18:0]);
         @(posedge clk);
         @(negedge clk);
         check(outs() == VEC[i][6:0], $sformatf("R%0d vec%0d", VEC[i][22:19], i),
               {1'b0, outs()}, {1'b0, VEC[i][6:0]});
      end

      // R9 output enable acts between edges on an open read
      apply(19'b101_111_11_1111_00_0000_0);
      oe_n = 1'b1; #1;
      check(dq_drive == 1'b0, "R9 oe high", {7'b0, dq_drive}, 8'h00);
      oe_n = 1'b0; #1;
      check(dq_drive == 1'b1, "R9 oe low", {7'b0, dq_drive}, 8'h01);

      // R10 sleep floats at once and ignores a write start
      sleep = 1'b1; #1;
      check(dq_drive == 1'b0, "R10 sleep float", {7'b0, dq_drive}, 8'h00);
      apply(19'b010_101_01_1111_00_0000_0);
      @(posedge clk); @(negedge clk);
      check(outs() == 7'b0, "R10 asleep", {1'b0, outs()}, 8'h00);

      // R11 two wake edges ignored
      sleep = 1'b0;
      for (int w = 0; w < 2; w++) begin
         @(posedge clk); @(negedge clk);
         check(addr_load == 1'b0 && lane_we == '0, $sformatf("R11 wake%0d", w),
               {1'b0, outs()}, {1'b0, 7'b0000001});
      end
      // R11 state preserved: continue of the old read burst
      apply(19'b101_110_11_1111_00_0000_0);
      @(posedge clk); @(negedge clk);
      check(outs() == 7'b0100001, "R11 resume", {1'b0, outs()}, 8'h21);

      // R1 asynchronous reset mid-burst
      rst_n = 1'b0; #1;
      check(outs() == 7'b0, "R1 reset mid", {1'b0, outs()}, 8'h00);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check(outs() == 7'b0, "R1 closed after reset", {1'b0, outs()}, 8'h00);

      done = 1'b1;
      finish_run();
   end

endmodule